// File: doc/BRIEF.md
# Direct-Mapped Cache Index Invalidator

This block carries out the privileged "clear one data cache line by index" operation of a processor core with a direct-mapped data cache. It takes a 32-bit I-type instruction word together with the value already read from the base register. When the word carries the operation's opcode, the block adds the sign-extended 16-bit offset to the base value. It then uses only the index field of the resulting address to pick a line. One cycle later it issues a write to the tag store's valid and dirty arrays that clears both bits of that line.

The operation never compares tags and never looks at the dirty bit. As a result, modified data held in the line is thrown away and is not written back to memory. Software is expected to run this operation over every index after reset, before it touches data memory. For that reason, reset does not clear any line.

If the instruction arrives in user mode, the block raises a privilege exception instead and leaves the cache state unchanged. If the core is built without a data cache, the operation completes without writing anything.

Top module: `dcache_line_clear`

## Requirements
- R1: The operation is recognised only when `instr_valid` is 1, instruction bits [5:0] equal 0x33 and bits [26:22] are all zero. Any other word produces no write, no done, no busy and no exception.
- R2: `src_reg` always shows instruction bits [31:27], the index of the base register, combinationally.
- R3: The effective address is `base_val` plus instruction bits [21:6] sign-extended to 32 bits, taken modulo 2^32. Negative offsets and wrap-around are allowed.
- R4: The cleared line is effective-address bits [OFF_W+IDX_W-1:OFF_W], where OFF_W = log2(LINE_BYTES) and IDX_W = log2(NUM_LINES). With the defaults this is bits [10:5]. The byte-offset bits and the tag bits have no effect on the line chosen.
- R5: An operation recognised in supervisor mode drives `tag_we` to 1 in the following cycle, with `tag_idx` set to its line and `tag_valid_wd` and `tag_dirty_wd` both 0. `tag_idx` holds its last written value while `tag_we` is 0, and reads 0 after reset.
- R6: `done` and `busy` pulse high in exactly the cycle of the write, once per operation. Back-to-back operations produce writes in consecutive cycles.
- R7: An operation recognised in user mode (`supervisor` = 0) raises `priv_exc` for one cycle in the following cycle. In that case there is no write, no done and no busy.
- R8: With HAS_DCACHE = 0, a supervisor operation pulses `done` in the following cycle and never raises `tag_we` or `busy`. User mode still raises `priv_exc`.
- R9: While `rst` is sampled high, the next cycle shows `tag_we`, `done`, `busy` and `priv_exc` all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | I-type instruction word |
| base_val | input | 32 | Value of the base register |
| supervisor | input | 1 | 1 = supervisor mode, 0 = user mode |
| src_reg | output | 5 | Base register index taken from the instruction |
| tag_we | output | 1 | Write strobe into the tag store's valid/dirty arrays |
| tag_idx | output | IDX_W | Line index being written |
| tag_valid_wd | output | 1 | Valid bit written (always 0) |
| tag_dirty_wd | output | 1 | Dirty bit written (always 0) |
| done | output | 1 | Operation completion pulse |
| busy | output | 1 | Blocks a lookup to the same index this cycle |
| priv_exc | output | 1 | Privilege exception pulse |

## Verification
The bench builds two copies of the block from the same stimulus. The first uses the defaults of 32-byte lines, 64 lines and a data cache present, so index bits [10:5] can be checked against addresses whose tag and offset bits vary freely. The second has HAS_DCACHE = 0, which brings the no-cache completion path and its silent write port into reach. Offsets near ±32768 and base values near 2^32 exercise the sign extension and the address wrap. The bench also drives words with a correct opcode but non-zero bits [26:22] to cover the decode boundary.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

  localparam logic [5:0] OPC_LINE_CLR = 6'h33;

  typedef struct packed {
    logic [4:0]  src;
    logic [4:0]  pad;
    logic [15:0] imm;
    logic [5:0]  opc;
  } itype_t;

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] eff_addr(input logic [31:0] base,
                                           input logic [15:0] imm);
    return base + sext16(imm);
  endfunction

endpackage

// File: rtl/dcl_decode.sv
module dcl_decode
  import dcl_pkg::*;
(
  input  logic        instr_valid,
  input  logic [31:0] instr,
  output logic        hit,
  output logic [4:0]  src_reg,
  output logic [15:0] imm
);

  itype_t word;

  always_comb begin
    word    = itype_t'(instr);
    src_reg = word.src;
    imm     = word.imm;
    hit     = instr_valid && (word.opc == OPC_LINE_CLR) && (word.pad == 5'd0);
  end

endmodule

// File: rtl/dcl_addr.sv
module dcl_addr
  import dcl_pkg::*;
#(
  parameter int OFF_W = 5,
  parameter int IDX_W = 6
) (
  input  logic [31:0]      base_val,
  input  logic [15:0]      imm,
  output logic [IDX_W-1:0] line_idx
);

  logic [31:0] ea;

  always_comb begin
    ea       = eff_addr(base_val, imm);
    line_idx = IDX_W'(ea >> OFF_W);
  end

endmodule

// File: rtl/dcl_issue.sv
module dcl_issue #(
  parameter int IDX_W      = 6,
  parameter bit HAS_DCACHE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             supervisor,
  input  logic [IDX_W-1:0] line_idx,
  output logic             tag_we,
  output logic [IDX_W-1:0] tag_idx,
  output logic             done,
  output logic             busy,
  output logic             priv_exc
);

  logic accept_sup;
  logic accept_usr;
  logic we_d;
  logic done_d;

  assign accept_sup = hit && supervisor;
  assign accept_usr = hit && !supervisor;

  generate
    if (HAS_DCACHE) begin : g_cache
      assign we_d   = accept_sup;
      assign done_d = accept_sup;
    end else begin : g_nocache
      assign we_d   = 1'b0;
      assign done_d = accept_sup;
      assert_nocache_silent_R8: assert property (@(posedge clk) disable iff (rst)
        !tag_we && !busy);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_we   <= 1'b0;
      tag_idx  <= '0;
      done     <= 1'b0;
      busy     <= 1'b0;
      priv_exc <= 1'b0;
    end else begin
      tag_we   <= we_d;
      busy     <= we_d;
      done     <= done_d;
      priv_exc <= accept_usr;
      if (we_d) tag_idx <= line_idx;
    end
  end

  assert_write_needs_super_R5: assert property (@(posedge clk) disable iff (rst)
    tag_we |-> $past(hit && supervisor));
  assert_exc_from_user_R7: assert property (@(posedge clk) disable iff (rst)
    priv_exc |-> $past(hit && !supervisor));
  assert_exc_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    priv_exc |-> (!tag_we && !done && !busy));
  assert_write_signals_done_R6: assert property (@(posedge clk) disable iff (rst)
    tag_we |-> (done && busy));
  assert_idx_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!tag_we && !$past(rst)) |-> $stable(tag_idx));

endmodule

// File: rtl/dcache_line_clear.sv
module dcache_line_clear #(
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 64,
  parameter bit HAS_DCACHE = 1'b1,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_valid,
  input  logic [31:0]      instr,
  input  logic [31:0]      base_val,
  input  logic             supervisor,
  output logic [4:0]       src_reg,
  output logic             tag_we,
  output logic [IDX_W-1:0] tag_idx,
  output logic             tag_valid_wd,
  output logic             tag_dirty_wd,
  output logic             done,
  output logic             busy,
  output logic             priv_exc
);

  logic             op_hit;
  logic [15:0]      op_imm;
  logic [IDX_W-1:0] ea_idx;

  dcl_decode u_decode (
    .instr_valid (instr_valid),
    .instr       (instr),
    .hit         (op_hit),
    .src_reg     (src_reg),
    .imm         (op_imm)
  );

  dcl_addr #(.OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
    .base_val (base_val),
    .imm      (op_imm),
    .line_idx (ea_idx)
  );

  dcl_issue #(.IDX_W(IDX_W), .HAS_DCACHE(HAS_DCACHE)) u_issue (
    .clk        (clk),
    .rst        (rst),
    .hit        (op_hit),
    .supervisor (supervisor),
    .line_idx   (ea_idx),
    .tag_we     (tag_we),
    .tag_idx    (tag_idx),
    .done       (done),
    .busy       (busy),
    .priv_exc   (priv_exc)
  );

  // Invalidate clears both bits: no tag compare, no write-back.
  assign tag_valid_wd = 1'b0;
  assign tag_dirty_wd = 1'b0;

  assert_idx_tracks_ea_R4: assert property (@(posedge clk) disable iff (rst)
    tag_we |-> (tag_idx == $past(ea_idx)));
  assert_decode_gates_R1: assert property (@(posedge clk) disable iff (rst)
    (done || priv_exc) |-> $past(instr_valid && instr[5:0] == 6'h33 && instr[26:22] == 5'd0));

endmodule

// File: tb/dcache_line_clear_tb.sv
module dcache_line_clear_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] base_val = '0;
  logic        supervisor = 1'b0;

  logic [4:0] src_a, src_b;
  logic       we_a, we_b, vwd_a, vwd_b, dwd_a, dwd_b;
  logic [5:0] idx_a, idx_b;
  logic       done_a, done_b, busy_a, busy_b, exc_a, exc_b;

  int compared = 0;
  int mismatched = 0;

  // expected state for each instance
  int e_we, e_idx, e_done, e_busy, e_exc;
  int n_done, n_exc;

  always #2.5 clk = ~clk;

  dcache_line_clear u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .base_val(base_val), .supervisor(supervisor), .src_reg(src_a),
    .tag_we(we_a), .tag_idx(idx_a), .tag_valid_wd(vwd_a), .tag_dirty_wd(dwd_a),
    .done(done_a), .busy(busy_a), .priv_exc(exc_a));

  dcache_line_clear #(.HAS_DCACHE(1'b0)) u_dut_nc (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .base_val(base_val), .supervisor(supervisor), .src_reg(src_b),
    .tag_we(we_b), .tag_idx(idx_b), .tag_valid_wd(vwd_b), .tag_dirty_wd(dwd_b),
    .done(done_b), .busy(busy_b), .priv_exc(exc_b));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s act=%0d exp=%0d @%0t", req, what, act, exp, $time);
    end
  endtask

  // reference: index from address, computed with integer arithmetic
  function automatic int ref_idx(input longint base, input int imm16);
    longint off, ea;
    off = (imm16 >= 32768) ? imm16 - 65536 : imm16;
    ea  = (base + off + 64'd4294967296) % 64'd4294967296;
    return int'((ea / 32) % 64);
  endfunction

  function automatic bit ref_match(input logic v, input logic [31:0] w);
    return v && (w % 64 == 51) && (((w / 4194304) % 32) == 0);
  endfunction

  task automatic compare_all();
    chk("R2", "src_reg", src_a, instr / 134217728);
    chk("R2", "src_reg_nc", src_b, instr / 134217728);
    chk("R5", "tag_we", we_a, e_we);
    chk("R5", "tag_idx", idx_a, e_idx);
    chk("R5", "valid_wd", vwd_a, 0);
    chk("R5", "dirty_wd", dwd_a, 0);
    chk("R6", "done", done_a, e_done);
    chk("R6", "busy", busy_a, e_busy);
    chk("R7", "priv_exc", exc_a, e_exc);
    chk("R8", "nc_tag_we", we_b, 0);
    chk("R8", "nc_busy", busy_b, 0);
    chk("R8", "nc_done", done_b, n_done);
    chk("R8", "nc_priv_exc", exc_b, n_exc);
  endtask

  // one cycle: drive at negedge, model, compare at next negedge
  task automatic step(input logic r, input logic v, input logic [31:0] w,
                      input logic [31:0] b, input logic s);
    bit m;
    rst = r; instr_valid = v; instr = w; base_val = b; supervisor = s;
    m = ref_match(v, w);
    if (r) begin
      e_we = 0; e_idx = 0; e_done = 0; e_busy = 0; e_exc = 0;
      n_done = 0; n_exc = 0;
    end else begin
      e_we   = (m && s) ? 1 : 0;
      e_done = e_we;
      e_busy = e_we;
      e_exc  = (m && !s) ? 1 : 0;
      if (e_we == 1) e_idx = ref_idx(b, int'(w[21:6]));
      n_done = e_we;
      n_exc  = e_exc;
    end
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [31:0] mk(input int a, input int imm, input int pad, input int opc);
    return (a % 32) * 134217728 + (pad % 32) * 4194304 + (imm % 65536) * 64 + (opc % 64);
  endfunction

  initial begin
    repeat (300000) @(posedge clk);
    mismatched++;
    $display("FAIL R6 watchdog act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    e_we = 0; e_idx = 0; e_done = 0; e_busy = 0; e_exc = 0; n_done = 0; n_exc = 0;
    @(negedge clk);
    // R9: reset with a valid operation present
    step(1, 1, mk(3, 0, 0, 51), 32'h0000_0040, 1);
    step(1, 0, 0, 0, 0);
    // R3/R4/R5: positive offset
    step(0, 1, mk(6, 16'h0020, 0, 51), 32'h1234_0000, 1);
    // R3: negative offset
    step(0, 1, mk(7, 16'hFFE0, 0, 51), 32'h0000_0400, 1);
    // R3: wrap past 2^32
    step(0, 1, mk(1, 16'h7FFF, 0, 51), 32'hFFFF_FFF0, 1);
    // R4: tag and offset bits differ, same index
    step(0, 1, mk(2, 16'h001F, 0, 51), 32'hABCD_0160, 1);
    // R6: idle cycle, idx must hold
    step(0, 0, mk(2, 16'h0100, 0, 51), 32'h0, 1);
    // R7: user mode
    step(0, 1, mk(4, 16'h0040, 0, 51), 32'h0000_0000, 0);
    // R1: non-zero reserved bits, wrong opcode
    step(0, 1, mk(4, 16'h0040, 1, 51), 32'h0, 1);
    step(0, 1, mk(4, 16'h0040, 16, 51), 32'h0, 1);
    step(0, 1, mk(4, 16'h0040, 0, 50), 32'h0, 1);
    step(0, 1, mk(4, 16'h0040, 0, 19), 32'h0, 0);
    // R6: back-to-back
    for (int i = 0; i < 64; i++)
      step(0, 1, mk(i, i * 32, 0, 51), 32'h0, 1);
    // R9: reset mid-stream
    step(1, 1, mk(5, 0, 0, 51), 32'h20, 1);
    step(0, 0, 0, 0, 1);
    // mixed patterns
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] w;
      int pad, opc;
      pad = ($urandom % 4 == 0) ? int'($urandom % 32) : 0;
      opc = ($urandom % 5 == 0) ? int'($urandom % 64) : 51;
      w = mk(int'($urandom % 32), int'($urandom % 65536), pad, opc);
      step(($urandom % 97) == 0, ($urandom % 4) != 0, w, $urandom, ($urandom % 3) != 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule